// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Interface

This block is the digital register file of a four-channel, 12-bit converter. Each channel has two ranks of storage. The first rank is an input register that a parallel bus writes and reads. The second rank is a DAC register that feeds the converter code output. A shared active-low load strobe moves every input register into its DAC register at once. A system designer can therefore stage new codes on all channels and apply them together. If the load strobe is held low permanently, each write goes straight through to the output.

The registers behave as level-sensitive latches. This is modelled synchronously: on every rising edge of the system clock, a register whose enable condition holds loads its input. Otherwise it keeps its value. On each edge the bus inputs are decoded into one of four named bus operations: `OP_RESET`, `OP_WRITE`, `OP_READ` and `OP_IDLE`. A state register keeps the last decoded operation and the last address. The output process drives the readback port from them. There are four transitions, one into each operation, taken on an edge according to the bus pins. Reset low forces `OP_RESET`. With reset high, chip select high gives `OP_IDLE`. With reset high and chip select low, read/write low gives `OP_WRITE` and read/write high gives `OP_READ`. The reset code is chosen by a parameter: mid-scale for bipolar parts and zero for unipolar parts.

Top module: `quad_dac_regs`

## Requirements
- R1: On a rising edge with `bus_rst_n` low, every input register and every DAC register takes the reset code, whatever the other inputs are. After that edge `rd_oe` is 0 and `rd_data` is 0.
- R2: The reset code is 12'h800 when `BIPOLAR` is 1 and 12'h000 when `BIPOLAR` is 0.
- R3: On a rising edge with `bus_rst_n`=1, `cs_n`=0 and `rd_wr`=0 (write), the input register selected by `addr` loads `wr_data`. The channel encoding is 0=A, 1=B, 2=C, 3=D.
- R4: A write changes only the addressed input register; the other three keep their values.
- R5: On a rising edge with `ldac_n`=0, every DAC register loads the value its input register holds after that edge. On an edge with `ldac_n`=1 and reset high, all DAC registers hold.
- R6: On a rising edge with `bus_rst_n`=1, `cs_n`=0 and `rd_wr`=1 (read), `rd_oe` becomes 1 and `rd_data` shows the addressed input register. No input register changes.
- R7: After an edge that is not a read, `rd_oe` is 0 and `rd_data` is 0.
- R8: On an edge with `cs_n`=1, no input register changes, whatever `wr_data` and `rd_wr` are.
- R9: When reset is released, every register keeps the reset code until it is written or loaded.
- R10: A write on an edge where `ldac_n` is also 0 reaches the channel's slice of `dac_out` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers update on its rising edge |
| bus_rst_n | input | 1 | Active-low reset of both register ranks |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ldac_n | input | 1 | Active-low load strobe for all DAC registers |
| addr | input | 2 | Channel select (0=A, 1=B, 2=C, 3=D) |
| wr_data | input | 12 | Write data for the addressed input register |
| rd_data | output | 12 | Readback of the addressed input register, zero when not reading |
| rd_oe | output | 1 | High while readback data is valid (tri-state enable) |
| dac_out | output | 48 | DAC register codes; channel i occupies bits [12*i+11:12*i] |

## Verification
Every result of this block is due one rising edge after the bus inputs that cause it. This covers input and DAC register loads, the same-edge pass-through when `ldac_n` is low, the reset forcing and the readback flag and data. The bench changes the bus on the falling edge. It then samples every DAC slice, `rd_oe` and `rd_data` 1 ns after the next rising edge. A reference model in the bench is advanced once per edge from the requirement rules. A second instance built as the unipolar variant confirms the zero reset code.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RESET = 2'd3
    } bus_op_t;
endpackage

// File: rtl/qdac_bus_decode.sv
module qdac_bus_decode
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              bus_rst_n,
    input  logic              cs_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op,
    output logic [NUM_CH-1:0] sel
);
    always_comb begin
        unique casez ({bus_rst_n, cs_n, rd_wr})
            3'b0??:  op = OP_RESET;
            3'b11?:  op = OP_IDLE;
            3'b100:  op = OP_WRITE;
            3'b101:  op = OP_READ;
            default: op = OP_IDLE;
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
    import qdac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  bus_op_t           op,
    input  logic              sel,
    input  logic              ldac_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] dac_q
);
    logic [DATA_W-1:0] in_next;

    always_comb begin
        in_next = in_q;
        if (op == OP_WRITE && sel) in_next = wr_data;
    end

    always_ff @(posedge clk) begin
        if (op == OP_RESET) begin
            in_q  <= RST_VAL;
            dac_q <= RST_VAL;
        end else begin
            in_q <= in_next;
            if (!ldac_n) dac_q <= in_next;
        end
    end
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import qdac_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int NUM_CH  = 4,
    parameter bit BIPOLAR = 1'b1,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam logic [DATA_W-1:0] RST_VAL =
        BIPOLAR ? (DATA_W'(1) << (DATA_W - 1)) : '0
) (
    input  logic                     clk,
    input  logic                     bus_rst_n,
    input  logic                     cs_n,
    input  logic                     rd_wr,
    input  logic                     ldac_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_oe,
    output logic [NUM_CH*DATA_W-1:0] dac_out
);
    bus_op_t             op_d, op_q;
    logic [ADDR_W-1:0]   rd_sel_q;
    logic [NUM_CH-1:0]   sel;
    logic [DATA_W-1:0]   in_q  [NUM_CH];
    logic [DATA_W-1:0]   dac_q [NUM_CH];

    qdac_bus_decode #(.NUM_CH(NUM_CH)) u_dec (
        .bus_rst_n (bus_rst_n),
        .cs_n      (cs_n),
        .rd_wr     (rd_wr),
        .addr      (addr),
        .op        (op_d),
        .sel       (sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        qdac_chan #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_chan (
            .clk     (clk),
            .op      (op_d),
            .sel     (sel[i]),
            .ldac_n  (ldac_n),
            .wr_data (wr_data),
            .in_q    (in_q[i]),
            .dac_q   (dac_q[i])
        );
        assign dac_out[i*DATA_W +: DATA_W] = dac_q[i];
    end

    // State register: last decoded bus operation and address
    always_ff @(posedge clk) begin
        op_q     <= op_d;
        rd_sel_q <= addr;
    end

    // Output process
    always_comb begin
        rd_oe   = 1'b0;
        rd_data = '0;
        unique case (op_q)
            OP_READ: begin
                rd_oe   = 1'b1;
                rd_data = in_q[rd_sel_q];
            end
            OP_IDLE, OP_WRITE, OP_RESET: begin
                rd_oe   = 1'b0;
                rd_data = '0;
            end
            default: begin
                rd_oe   = 1'b0;
                rd_data = '0;
            end
        endcase
    end
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int DATA_W  = 12,
    parameter int NUM_CH  = 4,
    parameter bit BIPOLAR = 1'b1,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam logic [DATA_W-1:0] RST_VAL =
        BIPOLAR ? (DATA_W'(1) << (DATA_W - 1)) : '0,
    localparam logic [NUM_CH*DATA_W-1:0] ALL_RST = {NUM_CH{RST_VAL}}
) (
    input logic                     clk,
    input logic                     bus_rst_n,
    input logic                     cs_n,
    input logic                     rd_wr,
    input logic                     ldac_n,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     rd_oe,
    input logic [NUM_CH*DATA_W-1:0] dac_out
);
    logic armed;
    logic prev_rst_low;

    always_ff @(posedge clk) begin
        armed        <= 1'b1;
        prev_rst_low <= !bus_rst_n;
    end

    // R1 / R2: after a reset edge all DAC codes equal the reset code
    always_ff @(posedge clk) begin
        if (armed && prev_rst_low) begin
            assert_reset_code_R1: assert (dac_out == ALL_RST && !rd_oe && rd_data == '0);
        end
    end

    assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!bus_rst_n)
        ldac_n |=> $stable(dac_out));

    assert_read_oe_R6: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (!cs_n && rd_wr) |=> rd_oe);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!bus_rst_n)
        cs_n |=> (!rd_oe && rd_data == '0));

    assert_pass_through_R10: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (!ldac_n && !cs_n && !rd_wr) |=>
            dac_out[$past(addr)*DATA_W +: DATA_W] == $past(wr_data));
endmodule

bind quad_dac_regs qdac_checker #(
    .DATA_W  (DATA_W),
    .NUM_CH  (NUM_CH),
    .BIPOLAR (BIPOLAR)
) u_chk (
    .clk       (clk),
    .bus_rst_n (bus_rst_n),
    .cs_n      (cs_n),
    .rd_wr     (rd_wr),
    .ldac_n    (ldac_n),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .dac_out   (dac_out)
);

// File: tb/tb_quad_dac_regs.sv
module tb_quad_dac_regs;
    localparam int DW = 12;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          bus_rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_wr = 1'b0;
    logic          ldac_n = 1'b1;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, rd_data_u;
    logic          rd_oe, rd_oe_u;
    logic [NC*DW-1:0] dac_out, dac_out_u;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [DW-1:0] m_in  [NC];
    logic [DW-1:0] m_dac [NC];
    logic          m_oe;
    logic [DW-1:0] m_rd;

    always #5 clk = ~clk;

    quad_dac_regs #(.DATA_W(DW), .NUM_CH(NC), .BIPOLAR(1'b1)) dut (
        .clk(clk), .bus_rst_n(bus_rst_n), .cs_n(cs_n), .rd_wr(rd_wr),
        .ldac_n(ldac_n), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_oe(rd_oe), .dac_out(dac_out));

    quad_dac_regs #(.DATA_W(DW), .NUM_CH(NC), .BIPOLAR(1'b0)) dut_uni (
        .clk(clk), .bus_rst_n(bus_rst_n), .cs_n(cs_n), .rd_wr(rd_wr),
        .ldac_n(ldac_n), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data_u), .rd_oe(rd_oe_u), .dac_out(dac_out_u));

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive on falling edge, model the edge, sample 1 ns after it
    task automatic step(input logic rst, input logic cs, input logic rw, input logic ld,
                        input logic [1:0] a, input logic [DW-1:0] d, input string tag);
        logic [DW-1:0] nxt [NC];
        @(negedge clk);
        bus_rst_n = rst; cs_n = cs; rd_wr = rw; ldac_n = ld; addr = a; wr_data = d;
        @(posedge clk);
        for (int i = 0; i < NC; i++) nxt[i] = m_in[i];
        if (!rst) begin
            for (int i = 0; i < NC; i++) begin m_in[i] = 12'h800; m_dac[i] = 12'h800; end
            m_oe = 1'b0; m_rd = '0;
        end else begin
            if (!cs && !rw) nxt[a] = d;
            for (int i = 0; i < NC; i++) begin
                m_in[i] = nxt[i];
                if (!ld) m_dac[i] = nxt[i];
            end
            m_oe = !cs && rw;
            m_rd = m_oe ? m_in[a] : '0;
        end
        #1;
        for (int i = 0; i < NC; i++) check(tag, dac_out[i*DW +: DW], m_dac[i]);
        check(tag, {11'd0, rd_oe}, {11'd0, m_oe});
        check(tag, rd_data, m_rd);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                checks++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < NC; i++) begin m_in[i] = 'x; m_dac[i] = 'x; end
        m_oe = 1'b0; m_rd = '0;
        // R1: reset with the other pins in write / load patterns
        step(0, 0, 0, 0, 2'd1, 12'hABC, "R1");
        step(0, 0, 1, 1, 2'd2, 12'h123, "R1");
        step(0, 1, 0, 0, 2'd3, 12'hFFF, "R1");
        // R2: reset codes of both variants
        check("R2", dac_out[DW-1:0], 12'h800);
        for (int i = 0; i < NC; i++) check("R2", dac_out_u[i*DW +: DW], 12'h000);
        // R9: released, idle, then read back each reset value
        step(1, 1, 0, 1, 2'd0, 12'h555, "R9");
        for (int c = 0; c < NC; c++) begin
            step(1, 0, 1, 1, 2'(c), 12'h000, "R9");
            check("R2", rd_data_u, 12'h000);
        end
        // R3/R4/R6 sweep: write with load held high, read back all channels
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 6; k++) begin
                v = DW'((k * 12'h3A5 + c * 12'h111) ^ (k == 5 ? 12'hFFF : 12'h000));
                step(1, 0, 0, 1, 2'(c), v, "R3");
                step(1, 0, 1, 1, 2'(c), ~v, "R6");
            end
            for (int r = 0; r < NC; r++) step(1, 0, 1, 1, 2'(r), 12'h000, "R4");
        end
        // R8: chip select high ignores write data
        for (int c = 0; c < NC; c++) step(1, 1, 0, 1, 2'(c), 12'h0F0, "R8");
        for (int c = 0; c < NC; c++) step(1, 0, 1, 1, 2'(c), 12'h000, "R8");
        // R5: load strobe moves all input registers
        step(1, 1, 0, 0, 2'd0, 12'h000, "R5");
        step(1, 1, 0, 1, 2'd0, 12'h000, "R5");
        // R10: load held low, writes pass straight through
        for (int c = 0; c < NC; c++) begin
            step(1, 0, 0, 0, 2'(c), DW'(12'h9A0 + c), "R10");
            step(1, 0, 0, 0, 2'(c), 12'h000, "R10");
            step(1, 0, 0, 0, 2'(c), 12'hFFF, "R10");
        end
        // R6: read with load low changes nothing
        for (int c = 0; c < NC; c++) step(1, 0, 1, 0, 2'(c), 12'h3C3, "R6");
        // R7: idle and write cycles give zero readback
        step(1, 1, 1, 1, 2'd2, 12'h777, "R7");
        step(1, 0, 0, 1, 2'd2, 12'h777, "R7");
        // R1/R9: reset in mid run, then release
        step(0, 0, 0, 0, 2'd0, 12'h111, "R1");
        step(1, 1, 0, 1, 2'd0, 12'h000, "R9");
        for (int c = 0; c < NC; c++) step(1, 0, 1, 1, 2'(c), 12'h000, "R9");
        done = 1'b1;
        finish_run();
    end
endmodule